// File: doc/BRIEF.md
# Parallel ADC Bus Read Controller

This block sits on the host side of a parallel successive-approximation ADC that shares a chip-enable strobe between starting conversions and reading results. When it accepts a command, it runs one conversion strobe and then waits for the converter's busy/status line to drop. It then runs one or two read strobes and hands back a 12-bit result. Every setup, hold and pulse-width minimum is stored as a time in nanoseconds and turned into system clock cycles at elaboration, rounded up. Each strobe therefore meets its minimum at any clock rate.

The result can be collected in two ways. In wide mode, the format pin is driven high and a single read returns all twelve data lines. In narrow mode, the format pin is driven low. The controller then reads two bytes from the upper eight data lines, using the byte-address pin to choose which, and rebuilds the left-justified word. A conversion whose status line never falls is abandoned after a programmed number of cycles, and a flagged result is returned.

Commands enter through a valid/ready pair. Results leave through a second valid/ready pair: a result stays posted, with its data and error flag held, until the consumer asserts ready. This is the only back-pressure path. No new command is taken while a result is waiting.

Top module: `adcrd_ctrl`

## Requirements
- R1: While reset is asserted, and on the first cycle after it is released: chip enable is low, chip select (active low) is high, `cmd_ready` is high and `res_valid` is low.
- R2: Conversion strobe. Chip select is low and read/convert is low (0 = convert) for at least ceil(SETUP_NS/CLK_PERIOD_NS) cycles before chip enable rises. Chip enable stays high for exactly ceil(CE_WIDTH_NS/CLK_PERIOD_NS) cycles, and chip select stays low for the whole time it is high. Chip select and read/convert do not change for at least ceil(HOLD_NS/CLK_PERIOD_NS) cycles after chip enable falls.
- R3: Read strobe. Read/convert is high (1 = read), chip select is low, and the byte address is set up by the same minimum cycle count as in R2 before chip enable rises. Chip enable stays high for the same exact width. All three pins stay unchanged while chip enable is high and for the hold count after it falls.
- R4: A read strobe never rises while the status line is high. No read takes place until status has been seen falling after the conversion strobe. The status line is ignored for ceil(STS_RISE_NS/CLK_PERIOD_NS) cycles after the conversion hold ends.
- R5: Narrow mode (`cmd_wide`=0, format pin low). There are exactly two reads: byte address 0 first, then byte address 1. Both reads sample data lines [11:4]. The first read gives result[11:4]. The upper four lines of the second read give result[3:0].
- R6: Wide mode (`cmd_wide`=1, format pin high). There is exactly one read, and result[11:0] equals data lines [11:0]. The format pin equals the command's `cmd_wide` at every strobe of the transaction.
- R7: If status stays high for TIMEOUT_CYC cycles after the ignore window, no read is made. A result with `res_err`=1 and data 0 is posted exactly HOLD+WINDOW+TIMEOUT_CYC cycles after the conversion strobe falls.
- R8: `res_valid`, `res_data` and `res_err` stay stable while `res_ready` is low. The result is removed in the cycle after it is accepted, giving one result per accepted command.
- R9: `cmd_ready` is high only when no transaction is running and no result is waiting. `cmd_valid` raised while `cmd_ready` is low starts nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Controller can take a command |
| cmd_wide | input | 1 | 1 = one 12-bit read, 0 = two byte reads |
| res_valid | output | 1 | Result posted |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | 12 | Assembled conversion result |
| res_err | output | 1 | Conversion timed out; data is zero |
| adc_ce | output | 1 | Converter chip enable strobe |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_rc | output | 1 | Read (1) or convert (0) |
| adc_a0 | output | 1 | Byte address for narrow reads |
| adc_fmt12 | output | 1 | Data format pin: 1 = 12 lines, 0 = byte mode |
| adc_sts | input | 1 | Converter busy status, high while converting |
| adc_db | input | 12 | Converter data lines |

## Verification
The bound checker watches, on every cycle, the strobe protocol at the pins. It checks the exact chip-enable width, the setup count before each rising edge, that chip select is low and the address pins are frozen while the strobe is high, that no read strobe starts while status is high, and that a posted result stays held under back-pressure. Other behaviours can only be shown by the bench's scenarios against its converter model. These are the assembled values in both formats, the two-byte ordering, and the hold count after each strobe. They also include the exact cycle at which a timed-out conversion posts its flagged result, and data arriving only at the access time. Finally, the bench covers a late status rise, a near-maximum conversion time, and recovery after a timeout.

// File: rtl/adcrd_pkg.sv
`timescale 1ns/1ps
package adcrd_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_CV_SET,
    ST_CV_CE,
    ST_CV_HOLD,
    ST_STS_WIN,
    ST_BUSY,
    ST_RD_SET,
    ST_RD_CE,
    ST_RD_HOLD,
    ST_RESULT
  } adcrd_state_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    if (c == 0) c = 1;
    return c;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adcrd_phase_timer.sv
`timescale 1ns/1ps
// Down-counter shared by all timed phases; done when it reaches zero.
module adcrd_phase_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (load)           cnt_q <= load_val;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/adcrd_conv_watch.sv
`timescale 1ns/1ps
// Counts cycles spent waiting for the status line; flags the limit.
module adcrd_conv_watch #(
  parameter int LIMIT = 8000,
  parameter int W     = 13
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);

  logic [W-1:0] cnt_q;

  assign expired = (cnt_q == W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (!expired)   cnt_q <= cnt_q + 1'b1;
  end

endmodule

// File: rtl/adcrd_sync.sv
`timescale 1ns/1ps
// Brings the converter status line into the clock domain.
module adcrd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);

  generate
    if (STAGES == 0) begin : g_pass
      assign q = d;
    end else begin : g_chain
      logic [STAGES-1:0] sh_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else begin
          sh_q[0] <= d;
          for (int i = 1; i < STAGES; i++) sh_q[i] <= sh_q[i-1];
        end
      end
      assign q = sh_q[STAGES-1];
    end
  endgenerate

endmodule

// File: rtl/adcrd_assemble.sv
`timescale 1ns/1ps
// Builds the result word from one full read or two byte-lane reads.
module adcrd_assemble #(
  parameter int DW = 12,
  parameter int BW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          cap_full,
  input  logic          cap_hi,
  input  logic          cap_lo,
  input  logic [DW-1:0] db,
  output logic [DW-1:0] word
);

  localparam int LW = DW - BW;

  logic [BW-1:0] lane;
  assign lane = db[DW-1 -: BW];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        word <= '0;
    else if (clr)      word <= '0;
    else if (cap_full) word <= db;
    else if (cap_hi)   word[DW-1 -: BW] <= lane;
    else if (cap_lo)   word[LW-1:0] <= lane[BW-1 -: LW];
  end

endmodule

// File: rtl/adcrd_ctrl.sv
`timescale 1ns/1ps
module adcrd_ctrl
  import adcrd_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned SETUP_NS      = 50,
  parameter int unsigned CE_WIDTH_NS   = 150,
  parameter int unsigned HOLD_NS       = 50,
  parameter int unsigned STS_RISE_NS   = 200,
  parameter int unsigned TIMEOUT_CYC   = 8000,
  parameter int          STS_SYNC      = 2,
  parameter int          DW            = 12,
  parameter int          BW            = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  output logic          cmd_ready,
  input  logic          cmd_wide,
  output logic          res_valid,
  input  logic          res_ready,
  output logic [DW-1:0] res_data,
  output logic          res_err,
  output logic          adc_ce,
  output logic          adc_cs_n,
  output logic          adc_rc,
  output logic          adc_a0,
  output logic          adc_fmt12,
  input  logic          adc_sts,
  input  logic [DW-1:0] adc_db
);

  localparam int unsigned SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned CE_CYC    = ns_to_cyc(CE_WIDTH_NS, CLK_PERIOD_NS);
  localparam int unsigned HOLD_CYC  = ns_to_cyc(HOLD_NS, CLK_PERIOD_NS);
  localparam int unsigned WIN_CYC   = ns_to_cyc(STS_RISE_NS, CLK_PERIOD_NS);
  localparam int unsigned PH_MAX    = max_u(max_u(SETUP_CYC, CE_CYC), max_u(HOLD_CYC, WIN_CYC));
  localparam int          PH_W      = $clog2(PH_MAX + 1);
  localparam int          TMO_W     = $clog2(TIMEOUT_CYC + 1);

  adcrd_state_e st_q, st_d;
  logic wide_q, lo_q, err_q;
  logic ph_done, ph_load, tmo_hit, sts_s;
  logic [PH_W-1:0] ph_val;
  logic accept, cap_strobe, in_conv, in_read;

  assign accept     = cmd_valid && cmd_ready;
  assign cap_strobe = (st_q == ST_RD_CE) && ph_done;

  // ---------------- next state ----------------
  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (cmd_valid) st_d = ST_CV_SET;
      ST_CV_SET:  if (ph_done) st_d = ST_CV_CE;
      ST_CV_CE:   if (ph_done) st_d = ST_CV_HOLD;
      ST_CV_HOLD: if (ph_done) st_d = ST_STS_WIN;
      ST_STS_WIN: if (ph_done) st_d = ST_BUSY;
      ST_BUSY: begin
        if (!sts_s)       st_d = ST_RD_SET;
        else if (tmo_hit) st_d = ST_RESULT;
      end
      ST_RD_SET:  if (ph_done) st_d = ST_RD_CE;
      ST_RD_CE:   if (ph_done) st_d = ST_RD_HOLD;
      ST_RD_HOLD: if (ph_done) st_d = (!wide_q && !lo_q) ? ST_RD_SET : ST_RESULT;
      ST_RESULT:  if (res_ready) st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  // phase length loaded on every state entry
  always_comb begin
    unique case (st_d)
      ST_CV_SET, ST_RD_SET:   ph_val = PH_W'(SETUP_CYC - 1);
      ST_CV_CE,  ST_RD_CE:    ph_val = PH_W'(CE_CYC - 1);
      ST_CV_HOLD, ST_RD_HOLD: ph_val = PH_W'(HOLD_CYC - 1);
      ST_STS_WIN:             ph_val = PH_W'(WIN_CYC - 1);
      default:                ph_val = '0;
    endcase
  end
  assign ph_load = (st_d != st_q);

  // ---------------- state and transaction registers ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      wide_q <= 1'b0;
      lo_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      if (accept) begin
        wide_q <= cmd_wide;
        lo_q   <= 1'b0;
        err_q  <= 1'b0;
      end
      if (st_q == ST_RD_HOLD && ph_done && !wide_q && !lo_q) lo_q <= 1'b1;
      if (st_q == ST_BUSY && sts_s && tmo_hit) err_q <= 1'b1;
    end
  end

  // ---------------- pin decode ----------------
  assign in_conv   = (st_q == ST_CV_SET) || (st_q == ST_CV_CE) || (st_q == ST_CV_HOLD);
  assign in_read   = (st_q == ST_RD_SET) || (st_q == ST_RD_CE) || (st_q == ST_RD_HOLD);
  assign adc_ce    = (st_q == ST_CV_CE) || (st_q == ST_RD_CE);
  assign adc_cs_n  = !(in_conv || in_read);
  assign adc_rc    = in_read;
  assign adc_a0    = in_read && lo_q && !wide_q;
  assign adc_fmt12 = wide_q;

  assign cmd_ready = (st_q == ST_IDLE);
  assign res_valid = (st_q == ST_RESULT);
  assign res_err   = err_q;

  // ---------------- sub-blocks ----------------
  adcrd_phase_timer #(.W(PH_W)) u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (ph_load),
    .load_val (ph_val),
    .done     (ph_done)
  );

  adcrd_conv_watch #(.LIMIT(int'(TIMEOUT_CYC)), .W(TMO_W)) u_watch (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st_q == ST_BUSY),
    .expired (tmo_hit)
  );

  adcrd_sync #(.STAGES(STS_SYNC)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (adc_sts),
    .q     (sts_s)
  );

  adcrd_assemble #(.DW(DW), .BW(BW)) u_asm (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr      (accept || (st_q == ST_BUSY && sts_s && tmo_hit)),
    .cap_full (cap_strobe && wide_q),
    .cap_hi   (cap_strobe && !wide_q && !lo_q),
    .cap_lo   (cap_strobe && !wide_q && lo_q),
    .db       (adc_db),
    .word     (res_data)
  );

endmodule

// File: rtl/adcrd_chk.sv
`timescale 1ns/1ps
module adcrd_chk
  import adcrd_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 4,
  parameter int unsigned SETUP_NS      = 50,
  parameter int unsigned CE_WIDTH_NS   = 150,
  parameter int          DW            = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_ready,
  input logic          res_valid,
  input logic          res_ready,
  input logic [DW-1:0] res_data,
  input logic          res_err,
  input logic          adc_ce,
  input logic          adc_cs_n,
  input logic          adc_rc,
  input logic          adc_a0,
  input logic          adc_fmt12,
  input logic          adc_sts
);

  localparam int unsigned SETUP_CYC = ns_to_cyc(SETUP_NS, CLK_PERIOD_NS);
  localparam int unsigned CE_CYC    = ns_to_cyc(CE_WIDTH_NS, CLK_PERIOD_NS);

  logic [15:0] ce_run, stab_cnt;
  logic [2:0]  addr_prev;
  logic [2:0]  addr_now;
  assign addr_now = {adc_cs_n, adc_rc, adc_a0};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ce_run    <= '0;
      stab_cnt  <= '0;
      addr_prev <= 3'b100;
    end else begin
      ce_run    <= adc_ce ? ce_run + 16'd1 : 16'd0;
      addr_prev <= addr_now;
      if (addr_now != addr_prev) stab_cnt <= 16'd1;
      else if (stab_cnt != 16'hFFFF) stab_cnt <= stab_cnt + 16'd1;
    end
  end

  a_r2_cs_during_ce: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ce |-> !adc_cs_n);

  a_r2_ce_width: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(adc_ce) |-> (32'(ce_run) == CE_CYC));

  a_r2_setup: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(adc_ce) |-> (32'(stab_cnt) + 1 >= SETUP_CYC));

  a_r3_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (adc_ce && $past(adc_ce)) |-> ($stable(adc_rc) && $stable(adc_a0) && $stable(adc_cs_n)));

  a_r4_no_read_busy: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(adc_ce) && adc_rc) |-> !adc_sts);

  a_r6_fmt_steady: assert property (@(posedge clk) disable iff (!rst_n)
    adc_ce |-> $stable(adc_fmt12));

  a_r8_result_held: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_err)));

  a_r9_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (!res_valid && adc_cs_n));

endmodule

bind adcrd_ctrl adcrd_chk #(
  .CLK_PERIOD_NS (CLK_PERIOD_NS),
  .SETUP_NS      (SETUP_NS),
  .CE_WIDTH_NS   (CE_WIDTH_NS),
  .DW            (DW)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_ready (cmd_ready),
  .res_valid (res_valid),
  .res_ready (res_ready),
  .res_data  (res_data),
  .res_err   (res_err),
  .adc_ce    (adc_ce),
  .adc_cs_n  (adc_cs_n),
  .adc_rc    (adc_rc),
  .adc_a0    (adc_a0),
  .adc_fmt12 (adc_fmt12),
  .adc_sts   (adc_sts)
);

// File: tb/tb_adcrd_ctrl.sv
`timescale 1ns/1ps
module tb_adcrd_ctrl;

  // cycle counts from the requirements at a 4 ns clock
  localparam int SETUP_C = 13;    // ceil(50/4)
  localparam int CE_C    = 38;    // ceil(150/4)
  localparam int HOLD_C  = 13;    // ceil(50/4)
  localparam int WIN_C   = 50;    // ceil(200/4)
  localparam int TMO_C   = 8000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmd_valid = 1'b0, cmd_wide = 1'b0, res_ready = 1'b0;
  logic cmd_ready, res_valid, res_err;
  logic [11:0] res_data;
  logic adc_ce, adc_cs_n, adc_rc, adc_a0, adc_fmt12;
  logic adc_sts = 1'b0;
  logic [11:0] adc_db;

  always #2 clk = ~clk;

  adcrd_ctrl #(
    .CLK_PERIOD_NS(4), .SETUP_NS(50), .CE_WIDTH_NS(150), .HOLD_NS(50),
    .STS_RISE_NS(200), .TIMEOUT_CYC(TMO_C), .STS_SYNC(2), .DW(12), .BW(8)
  ) dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_wide(cmd_wide), .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_err(res_err), .adc_ce(adc_ce), .adc_cs_n(adc_cs_n),
    .adc_rc(adc_rc), .adc_a0(adc_a0), .adc_fmt12(adc_fmt12), .adc_sts(adc_sts),
    .adc_db(adc_db)
  );

  int total = 0, bad = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- converter model ----------------
  int sts_dly = 30, conv_len = 2001;
  bit hang = 0;
  logic [11:0] conv_val = '0;
  bit acc_ok = 0;
  logic [11:0] bus_val;

  always @(posedge adc_ce) begin
    if (!adc_cs_n && !adc_rc) begin
      #(sts_dly);
      adc_sts = 1'b1;
      #(conv_len);
      wait (!hang);
      adc_sts = 1'b0;
    end
  end

  always @(posedge adc_ce) begin
    acc_ok = 1'b0;
    #150;
    if (adc_ce) acc_ok = 1'b1;
  end
  always @(negedge adc_ce) acc_ok = 1'b0;

  always_comb begin
    if (adc_fmt12)   bus_val = conv_val;
    else if (adc_a0) bus_val = {conv_val[3:0], 4'h0, 4'hF};
    else             bus_val = {conv_val[11:4], 4'hF};
  end
  assign adc_db = (!adc_cs_n && adc_rc && adc_ce && !adc_sts && acc_ok) ? bus_val : ~bus_val;

  // ---------------- per-clock protocol reference ----------------
  bit m_ce = 0, m_sts = 0, after_fall = 0, conv_fell = 0, moved = 0, exp_wide = 0, m_rc = 0;
  logic [2:0] m_addr = 3'b100, rise_addr = 3'b100;
  int m_stab = 0, m_hi = 0, m_lo = 0;
  int reads = 0, conv_starts = 0, t_fall = 0;
  logic [1:0] a0_log = '0;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [2:0] a_now;
      a_now = {adc_cs_n, adc_rc, adc_a0};
      if (adc_ce && !m_ce) begin
        chk(m_stab >= SETUP_C, adc_rc ? "R3" : "R2", "setup cycles", m_stab, SETUP_C);
        chk(!adc_cs_n, adc_rc ? "R3" : "R2", "cs_n at strobe", adc_cs_n, 0);
        chk(adc_fmt12 == exp_wide, "R6", "format pin", adc_fmt12, exp_wide);
        rise_addr = a_now;
        moved = 0;
        if (adc_rc) begin
          reads++;
          a0_log = {a0_log[0], adc_a0};
          chk(!adc_sts && conv_fell, "R4", "read after status low", {adc_sts, conv_fell}, 1);
        end else begin
          conv_starts++;
          conv_fell = 0;
        end
      end
      if (adc_ce && m_ce && a_now != rise_addr) moved = 1;
      if (!adc_ce && m_ce) begin
        chk(m_hi == CE_C, m_rc ? "R3" : "R2", "strobe width", m_hi, CE_C);
        chk(!moved && a_now == rise_addr, m_rc ? "R3" : "R2", "pins frozen in strobe", moved, 0);
        if (!m_rc) t_fall = cyc;
        after_fall = 1;
      end
      if (!adc_ce && !m_ce && a_now != m_addr) begin
        if (after_fall) chk(m_lo >= HOLD_C, m_rc ? "R3" : "R2", "hold cycles", m_lo, HOLD_C);
        after_fall = 0;
      end
      if (m_sts && !adc_sts) conv_fell = 1;
      m_stab = (a_now != m_addr) ? 1 : m_stab + 1;
      m_hi   = adc_ce ? (m_ce ? m_hi + 1 : 1) : 0;
      m_lo   = adc_ce ? 0 : (m_ce ? 1 : m_lo + 1);
      m_addr = a_now;
      if (adc_ce) m_rc = adc_rc;
      m_ce   = adc_ce;
      m_sts  = adc_sts;
    end
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    if (cyc > 150000) begin
      bad++; total++;
      $display("FAIL watchdog: actual=%0d expected=<150000", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // ---------------- transaction driver ----------------
  task automatic run_txn(input bit wide, input logic [11:0] val, input int dly_ns,
                         input int conv_ns, input bit hang_it, input int bp, input bit poke);
    int starts0;
    logic [11:0] held;
    string rq;
    rq = wide ? "R6" : "R5";
    sts_dly = dly_ns; conv_len = conv_ns; conv_val = val; hang = hang_it;
    exp_wide = wide; reads = 0; a0_log = '0; starts0 = conv_starts;
    @(negedge clk);
    cmd_wide = wide; cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!res_valid) @(negedge clk);
    if (hang_it) begin
      chk(res_err == 1'b1, "R7", "error flag", res_err, 1);
      chk(res_data == 12'h000, "R7", "data on timeout", res_data, 0);
      chk(reads == 0, "R7", "reads on timeout", reads, 0);
      chk(cyc - t_fall == HOLD_C + WIN_C + TMO_C, "R7", "timeout cycle", cyc - t_fall, HOLD_C + WIN_C + TMO_C);
    end else begin
      chk(res_err == 1'b0, rq, "error flag", res_err, 0);
      chk(res_data == val, rq, "result", res_data, val);
      chk(reads == (wide ? 1 : 2), rq, "read count", reads, wide ? 1 : 2);
      if (!wide) chk(a0_log == 2'b01, "R5", "byte order", a0_log, 2'b01);
    end
    held = res_data;
    for (int i = 0; i < bp; i++) begin
      if (poke && i == 2) cmd_valid = 1'b1;
      @(negedge clk);
      chk(res_valid && res_data == held, "R8", "result held", res_data, held);
      if (poke && i >= 2) chk(!cmd_ready && adc_cs_n, "R9", "ready while pending", cmd_ready, 0);
    end
    if (poke) begin
      cmd_valid = 1'b0;
      chk(conv_starts == starts0 + 1, "R9", "no extra conversion", conv_starts, starts0 + 1);
    end
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid && cmd_ready, "R8", "result removed once", res_valid, 0);
    if (hang_it) begin
      hang = 0;
      repeat (4) @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!adc_ce && adc_cs_n && cmd_ready && !res_valid, "R1", "pins in reset",
        {adc_ce, adc_cs_n, cmd_ready, res_valid}, 4'b0110);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!adc_ce && adc_cs_n && cmd_ready && !res_valid, "R1", "pins after reset",
        {adc_ce, adc_cs_n, cmd_ready, res_valid}, 4'b0110);

    run_txn(1'b0, 12'hA5C, 30, 2001, 0, 0, 0);    // R5 narrow
    run_txn(1'b1, 12'h3E7, 30, 2001, 0, 0, 0);    // R6 wide
    run_txn(1'b0, 12'hFFF, 45, 3001, 0, 0, 0);    // R5 all ones
    run_txn(1'b0, 12'h001, 45, 1501, 0, 0, 0);    // R5 lowest bit in second byte
    run_txn(1'b1, 12'h81F, 30, 2001, 0, 20, 1);   // R8/R9 back-pressure
    run_txn(1'b0, 12'h6B2, 197, 5001, 0, 3, 0);   // R4 late status rise
    run_txn(1'b1, 12'h000, 30, 2001, 1, 5, 0);    // R7 timeout
    run_txn(1'b1, 12'hC3A, 30, 2001, 0, 0, 0);    // recovery after timeout
    run_txn(1'b0, 12'h5D9, 30, 24999, 0, 0, 0);   // R4 long conversion

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule